// File: doc/BRIEF.md
# Packet Page Allocator with Command Queues

This block owns the page bookkeeping of a small network controller whose frame buffer is split into a handful of 2 KB pages (four by default). It keeps a bitmap of occupied pages and three page-number queues: frames waiting to be sent, frames already sent and waiting for software to acknowledge them, and received frames waiting to be read. The frame data memory and the frame layout are outside this block. Only page numbers pass through it.

Software drives it with 8-bit command writes. The top three bits pick one of eight operations on the bitmap and the queues. The receive path asks for pages through its own request line. The transmit engine takes pages from the send queue one per cycle while transmission is enabled. Pages can also be returned through a release input. A transmit allocation that finds no free page stays pending. It completes by itself as soon as any page is freed. Every update a request causes takes effect at one clock edge.

Top module: `pkt_page_mgr`

## Requirements
- R1: After reset, `alloc_result` is 0, both queue heads read 0x80, `pages_used` is 0, `mem_pages` is 4, and `ev_alloc_done`, `tx_valid` and `rx_grant` are low.
- R2: Command code 1 (`cmd_code[7:5]`) allocates the lowest-numbered free page. On the next cycle `alloc_result` holds that page number and `ev_alloc_done` pulses for one cycle. When no page is free, `alloc_result` becomes 0x80 and no pulse follows.
- R3: When any page is freed while `alloc_result` is 0x80, the lowest free page is taken in the same clock. `alloc_result` then shows it and `ev_alloc_done` pulses.
- R4: Code 2 frees every page, empties all three queues and sets `alloc_result` to 0.
- R5: `tx_done_head` and `rx_head` read 0x80 when their queue is empty. Otherwise they show the oldest page number in the queue.
- R6: Code 6 appends `pkt_num` to the send queue, which holds four entries. A push into a full queue is dropped.
- R7: While `tx_enable` is high and the send queue is not empty, `tx_valid` is high and `tx_page` shows the send-queue head. That entry is removed at the clock edge, so the queue drains in order. With `auto_release` high the sent page is freed. Otherwise the page is appended to the completion queue. That queue drops entries once it holds four. `done_ack` removes its head.
- R8: A receive request is granted (`rx_grant` high in the same cycle, `rx_page` = lowest free page) only when a page is free and the receive queue holds fewer than four entries. A granted page is marked used and appended to the receive queue.
- R9: Code 3 removes the receive-queue head. Code 4 removes it and frees its page. On an empty receive queue both codes leave the queue and the bitmap unchanged.
- R10: Code 5 frees the page named by `pkt_num`. Code 7 empties the send and completion queues. Code 0 changes nothing.
- R11: `pages_used` equals the number of occupied pages.
- R12: In any cycle, a command wins over a release. A release wins over a send-queue drain. A drain wins over a receive request. A request that loses is ignored in that cycle. `done_ack` is ignored in a command cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command write strobe |
| cmd_code | input | 8 | Command value; bits [7:5] select the operation |
| pkt_num | input | 2 | Page number used by codes 5 and 6 |
| tx_enable | input | 1 | Allows the send queue to drain |
| auto_release | input | 1 | Free sent pages instead of logging them |
| rel_valid | input | 1 | External page release strobe |
| rel_page | input | 2 | Page to release |
| rx_req | input | 1 | Receive path asks for a page |
| done_ack | input | 1 | Remove completion-queue head |
| rx_grant | output | 1 | Receive request granted this cycle |
| rx_page | output | 2 | Granted receive page |
| tx_valid | output | 1 | A page is handed to the transmit engine this cycle |
| tx_page | output | 2 | Page being sent |
| alloc_result | output | 8 | Transmit allocation result, 0x80 on failure |
| tx_done_head | output | 8 | Oldest completed page or 0x80 |
| rx_head | output | 8 | Oldest received page or 0x80 |
| pages_used | output | 3 | Count of occupied pages |
| mem_pages | output | 8 | Number of pages in the buffer |
| ev_alloc_done | output | 1 | One-cycle pulse on a successful transmit allocation |

## Verification
Several rules are checked on every cycle by properties. A granted receive page must be free, and the receive queue must have room. A pending allocation must complete after a release. A full-buffer allocation must fail. The reset command must empty the bitmap. A drain must never share a cycle with a command or a release. A full queue must stay full when a push is dropped, and an empty queue must stay empty when popped. Other behaviour only shows up in the bench's scenarios: lowest-free selection over every occupancy pattern, the first-in first-out order of each queue, the completion-queue cap, and auto-release freeing sent pages.

// File: rtl/pm_pkg.sv
package pm_pkg;
  typedef enum logic [2:0] {
    OP_NOP      = 3'd0,
    OP_TXALLOC  = 3'd1,
    OP_RESET    = 3'd2,
    OP_RXPOP    = 3'd3,
    OP_RXPOPFREE= 3'd4,
    OP_FREE     = 3'd5,
    OP_TXPUSH   = 3'd6,
    OP_TXCLR    = 3'd7
  } pm_op_e;

  localparam logic [7:0] FAIL_CODE = 8'h80;
endpackage

// File: rtl/pm_page_scan.sv
module pm_page_scan #(
  parameter int N_PAGES = 4,
  localparam int PW = (N_PAGES > 1) ? $clog2(N_PAGES) : 1
) (
  input  logic [N_PAGES-1:0] busy,
  output logic               found,
  output logic [PW-1:0]      idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N_PAGES - 1; i >= 0; i--) begin
      if (!busy[i]) begin
        found = 1'b1;
        idx   = PW'(i);
      end
    end
  end
endmodule

// File: rtl/pm_page_fifo.sv
module pm_page_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 2,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  input  logic         clr,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rd_q, rd_d, wr_q, wr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign do_push = push && !full && !clr;
  assign do_pop  = pop && !empty && !clr;
  assign head    = mem[rd_q];

  always_comb begin
    rd_d  = rd_q;
    wr_d  = wr_q;
    cnt_d = cnt_q;
    if (clr) begin
      rd_d  = '0;
      wr_d  = '0;
      cnt_d = '0;
    end else begin
      if (do_push) wr_d = (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
      if (do_pop)  rd_d = (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      rd_q  <= rd_d;
      wr_q  <= wr_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= wdata;
  end

  // R6: a dropped push leaves a full queue full
  p_full_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop && !clr) |=> full);
  // R9: popping an empty queue leaves it empty
  p_empty_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop && !push && !clr) |=> empty);
  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
endmodule

// File: rtl/pkt_page_mgr.sv
module pkt_page_mgr
  import pm_pkg::*;
#(
  parameter int N_PAGES = 4,
  parameter int Q_DEPTH = 4,
  localparam int PW = (N_PAGES > 1) ? $clog2(N_PAGES) : 1,
  localparam int CW = $clog2(N_PAGES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [7:0]    cmd_code,
  input  logic [PW-1:0] pkt_num,
  input  logic          tx_enable,
  input  logic          auto_release,
  input  logic          rel_valid,
  input  logic [PW-1:0] rel_page,
  input  logic          rx_req,
  input  logic          done_ack,
  output logic          rx_grant,
  output logic [PW-1:0] rx_page,
  output logic          tx_valid,
  output logic [PW-1:0] tx_page,
  output logic [7:0]    alloc_result,
  output logic [7:0]    tx_done_head,
  output logic [7:0]    rx_head,
  output logic [CW-1:0] pages_used,
  output logic [7:0]    mem_pages,
  output logic          ev_alloc_done
);
  pm_op_e               op;
  logic                 unused_cmd_lo;
  logic [N_PAGES-1:0]   bm_q, bm_d, bm_mid;
  logic [7:0]           res_q, res_d;
  logic                 ev_q, ev_d;
  logic                 free_en;
  logic [PW-1:0]        free_pg;
  logic                 found;
  logic [PW-1:0]        low_idx;
  logic                 rel_go, drain, rx_try;

  logic                 txq_push, txq_pop, txq_clr, txq_empty, txq_full;
  logic [PW-1:0]        txq_head;
  logic                 dq_push, dq_pop, dq_clr, dq_empty, dq_full;
  logic [PW-1:0]        dq_head;
  logic                 rxq_push, rxq_pop, rxq_clr, rxq_empty, rxq_full;
  logic [PW-1:0]        rxq_head;

  assign op            = pm_op_e'(cmd_code[7:5]);
  assign unused_cmd_lo = ^cmd_code[4:0];

  // Arbitration: command > release > drain > receive request
  assign rel_go = rel_valid && !cmd_valid;
  assign drain  = tx_enable && !txq_empty && !cmd_valid && !rel_valid;
  assign rx_try = rx_req && !cmd_valid && !rel_valid && !drain;

  // Which page, if any, is freed this cycle
  always_comb begin
    free_en = 1'b0;
    free_pg = '0;
    if (cmd_valid) begin
      if (op == OP_RXPOPFREE && !rxq_empty) begin
        free_en = 1'b1;
        free_pg = rxq_head;
      end else if (op == OP_FREE) begin
        free_en = 1'b1;
        free_pg = pkt_num;
      end
    end else if (rel_go) begin
      free_en = 1'b1;
      free_pg = rel_page;
    end else if (drain && auto_release) begin
      free_en = 1'b1;
      free_pg = txq_head;
    end
  end

  always_comb begin
    bm_mid = bm_q;
    if (free_en) bm_mid[free_pg] = 1'b0;
  end

  pm_page_scan #(.N_PAGES(N_PAGES)) i_scan (
    .busy  (bm_mid),
    .found (found),
    .idx   (low_idx)
  );

  // Next-state logic
  always_comb begin
    bm_d     = bm_mid;
    res_d    = res_q;
    ev_d     = 1'b0;
    txq_push = 1'b0; txq_pop = 1'b0; txq_clr = 1'b0;
    dq_push  = 1'b0; dq_pop  = done_ack && !cmd_valid; dq_clr = 1'b0;
    rxq_push = 1'b0; rxq_pop = 1'b0; rxq_clr = 1'b0;
    rx_grant = 1'b0;
    if (cmd_valid) begin
      case (op)
        OP_TXALLOC: begin
          if (found) begin
            bm_d[low_idx] = 1'b1;
            res_d         = 8'(low_idx);
            ev_d          = 1'b1;
          end else begin
            res_d = FAIL_CODE;
          end
        end
        OP_RESET: begin
          bm_d    = '0;
          res_d   = 8'h00;
          txq_clr = 1'b1;
          dq_clr  = 1'b1;
          rxq_clr = 1'b1;
        end
        OP_RXPOP, OP_RXPOPFREE: rxq_pop = 1'b1;
        OP_TXPUSH: txq_push = 1'b1;
        OP_TXCLR: begin
          txq_clr = 1'b1;
          dq_clr  = 1'b1;
        end
        default: ;
      endcase
    end
    if (drain) begin
      txq_pop = 1'b1;
      dq_push = !auto_release;
    end
    if (rx_try && found && !rxq_full) begin
      bm_d[low_idx] = 1'b1;
      rxq_push      = 1'b1;
      rx_grant      = 1'b1;
    end
    // Pending transmit allocation retried on any free
    if (free_en && res_q == FAIL_CODE && found) begin
      bm_d[low_idx] = 1'b1;
      res_d         = 8'(low_idx);
      ev_d          = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bm_q  <= '0;
      res_q <= 8'h00;
      ev_q  <= 1'b0;
    end else begin
      bm_q  <= bm_d;
      res_q <= res_d;
      ev_q  <= ev_d;
    end
  end

  pm_page_fifo #(.DEPTH(Q_DEPTH), .W(PW)) i_txq (
    .clk(clk), .rst_n(rst_n), .push(txq_push), .wdata(pkt_num), .pop(txq_pop),
    .clr(txq_clr), .head(txq_head), .empty(txq_empty), .full(txq_full)
  );

  pm_page_fifo #(.DEPTH(Q_DEPTH), .W(PW)) i_doneq (
    .clk(clk), .rst_n(rst_n), .push(dq_push), .wdata(txq_head), .pop(dq_pop),
    .clr(dq_clr), .head(dq_head), .empty(dq_empty), .full(dq_full)
  );

  pm_page_fifo #(.DEPTH(Q_DEPTH), .W(PW)) i_rxq (
    .clk(clk), .rst_n(rst_n), .push(rxq_push), .wdata(low_idx), .pop(rxq_pop),
    .clr(rxq_clr), .head(rxq_head), .empty(rxq_empty), .full(rxq_full)
  );

  always_comb begin
    pages_used = '0;
    for (int i = 0; i < N_PAGES; i++) pages_used = pages_used + CW'(bm_q[i]);
  end

  assign rx_page       = low_idx;
  assign tx_valid      = drain;
  assign tx_page       = txq_head;
  assign alloc_result  = res_q;
  assign ev_alloc_done = ev_q;
  assign tx_done_head  = dq_empty  ? FAIL_CODE : 8'(dq_head);
  assign rx_head       = rxq_empty ? FAIL_CODE : 8'(rxq_head);
  assign mem_pages     = 8'(N_PAGES);

  // R8: a grant hands out a free page into a queue with room
  p_grant_free_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_grant |-> (!bm_q[rx_page] && !rxq_full));
  // R3: a release with an allocation pending completes it
  p_retry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_valid && !cmd_valid && alloc_result == FAIL_CODE)
      |=> (alloc_result != FAIL_CODE && ev_alloc_done));
  // R2: allocation on a full buffer fails without an event
  p_full_fail_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code[7:5] == 3'd1 && pages_used == CW'(N_PAGES))
      |=> (alloc_result == FAIL_CODE && !ev_alloc_done));
  // R2: the event only accompanies a valid page number
  p_ev_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_alloc_done |-> !alloc_result[7]);
  // R4: reset command empties the bitmap
  p_reset_cmd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code[7:5] == 3'd2)
      |=> (pages_used == '0 && alloc_result == 8'h00));
  // R12: a drain never shares a cycle with a command or release
  p_prio_r12: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (!cmd_valid && !rel_valid && tx_enable));
endmodule

// File: tb/test_pkt_page_mgr.sv
`timescale 1ns/1ps
module test_pkt_page_mgr;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cmd_valid, tx_enable, auto_release, rel_valid, rx_req, done_ack;
  logic [7:0] cmd_code;
  logic [1:0] pkt_num, rel_page;
  logic       rx_grant, tx_valid, ev_alloc_done;
  logic [1:0] rx_page, tx_page;
  logic [7:0] alloc_result, tx_done_head, rx_head, mem_pages;
  logic [2:0] pages_used;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pkt_page_mgr i_pkt_page_mgr (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .pkt_num(pkt_num), .tx_enable(tx_enable), .auto_release(auto_release),
    .rel_valid(rel_valid), .rel_page(rel_page), .rx_req(rx_req),
    .done_ack(done_ack), .rx_grant(rx_grant), .rx_page(rx_page),
    .tx_valid(tx_valid), .tx_page(tx_page), .alloc_result(alloc_result),
    .tx_done_head(tx_done_head), .rx_head(rx_head), .pages_used(pages_used),
    .mem_pages(mem_pages), .ev_alloc_done(ev_alloc_done)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic cmd(input logic [2:0] op, input logic [1:0] pn);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_code = {op, 5'b10101}; pkt_num = pn;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_code = 8'h00;
  endtask

  task automatic rel(input logic [1:0] pg);
    @(negedge clk);
    rel_valid = 1'b1; rel_page = pg;
    @(negedge clk);
    rel_valid = 1'b0;
  endtask

  task automatic ack();
    @(negedge clk);
    done_ack = 1'b1;
    @(negedge clk);
    done_ack = 1'b0;
  endtask

  // receive request; returns grant and page seen before the edge
  task automatic rxreq(output logic g, output logic [1:0] pg);
    @(negedge clk);
    rx_req = 1'b1;
    #1;
    g = rx_grant; pg = rx_page;
    @(negedge clk);
    rx_req = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic       g;
    logic [1:0] pg;
    int         exp_low, pc;
    cmd_valid = 0; cmd_code = 0; pkt_num = 0; tx_enable = 0; auto_release = 0;
    rel_valid = 0; rel_page = 0; rx_req = 0; done_ack = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 alloc_result", alloc_result, 0);
    chk("R1 tx_done_head", tx_done_head, 8'h80);
    chk("R1 rx_head", rx_head, 8'h80);
    chk("R1 pages_used", pages_used, 0);
    chk("R1 mem_pages", mem_pages, 4);
    chk("R1 events", {ev_alloc_done, tx_valid, rx_grant}, 0);

    // R2 / R10 / R11: sweep every occupancy pattern
    for (int pat = 0; pat < 16; pat++) begin
      cmd(3'd2, 2'd0);
      for (int i = 0; i < 4; i++) begin
        cmd(3'd1, 2'd0);
        chk("R2 sequential alloc", alloc_result, i);
        chk("R2 alloc event", ev_alloc_done, 1);
      end
      for (int k = 0; k < 4; k++)
        if (((pat >> k) & 1) == 0) cmd(3'd5, 2'(k));
      pc = 0;
      exp_low = 8'h80;
      for (int k = 3; k >= 0; k--) begin
        if (((pat >> k) & 1) != 0) pc++;
        else exp_low = k;
      end
      chk("R11 pages_used", pages_used, pc);
      cmd(3'd0, 2'd0);
      chk("R10 nop keeps bitmap", pages_used, pc);
      cmd(3'd1, 2'd0);
      chk("R2 lowest free", alloc_result, exp_low);
      chk("R2 event on success only", ev_alloc_done, (exp_low != 8'h80) ? 1 : 0);
    end

    // R3: pending allocation completes on release
    for (int k = 0; k < 4; k++) begin
      cmd(3'd2, 2'd0);
      for (int i = 0; i < 5; i++) cmd(3'd1, 2'd0);
      chk("R2 full fails", alloc_result, 8'h80);
      rel(2'(k));
      chk("R3 retry page", alloc_result, k);
      chk("R3 retry event", ev_alloc_done, 1);
      chk("R3 retry keeps full", pages_used, 4);
    end
    cmd(3'd2, 2'd0);
    for (int i = 0; i < 5; i++) cmd(3'd1, 2'd0);
    cmd(3'd5, 2'd2);
    chk("R3 retry via free command", alloc_result, 2);

    // R5 / R6 / R7 queues
    cmd(3'd2, 2'd0);
    chk("R4 reset result", alloc_result, 0);
    chk("R4 reset bitmap", pages_used, 0);
    cmd(3'd6, 2'd2); cmd(3'd6, 2'd0); cmd(3'd6, 2'd3); cmd(3'd6, 2'd1);
    cmd(3'd6, 2'd2);
    chk("R5 done empty", tx_done_head, 8'h80);
    @(negedge clk);
    tx_enable = 1'b1;
    #1;
    for (int i = 0; i < 4; i++) begin
      chk("R7 tx_valid", tx_valid, 1);
      chk("R7 order", tx_page, (i == 0) ? 2 : (i == 1) ? 0 : (i == 2) ? 3 : 1);
      @(negedge clk); #1;
    end
    chk("R6 fifth push dropped", tx_valid, 0);
    tx_enable = 1'b0;
    chk("R5 done head oldest", tx_done_head, 2);
    ack();
    chk("R7 ack pops", tx_done_head, 0);
    cmd(3'd7, 2'd0);
    chk("R10 clear queues", tx_done_head, 8'h80);
    cmd(3'd6, 2'd1); cmd(3'd6, 2'd2); cmd(3'd6, 2'd3); cmd(3'd6, 2'd0);
    @(negedge clk); tx_enable = 1'b1;
    repeat (4) @(negedge clk);
    tx_enable = 1'b0;
    cmd(3'd6, 2'd3);
    @(negedge clk); tx_enable = 1'b1;
    @(negedge clk); tx_enable = 1'b0;
    for (int i = 0; i < 4; i++) begin
      chk("R7 completion order", tx_done_head, (i == 0) ? 1 : (i == 1) ? 2 : (i == 2) ? 3 : 0);
      ack();
    end
    chk("R7 completion cap", tx_done_head, 8'h80);

    // R7 auto release
    cmd(3'd2, 2'd0);
    cmd(3'd1, 2'd0); cmd(3'd1, 2'd0); cmd(3'd1, 2'd0);
    cmd(3'd6, 2'd1);
    auto_release = 1'b1;
    @(negedge clk); tx_enable = 1'b1;
    @(negedge clk); tx_enable = 1'b0; auto_release = 1'b0;
    chk("R7 auto release frees", pages_used, 2);
    chk("R7 auto release no log", tx_done_head, 8'h80);

    // R8 / R9 receive side
    cmd(3'd2, 2'd0);
    for (int i = 0; i < 4; i++) begin
      rxreq(g, pg);
      chk("R8 grant", g, 1);
      chk("R8 grant page", pg, i);
    end
    chk("R5 rx head", rx_head, 0);
    rxreq(g, pg);
    chk("R8 refuse all used", g, 0);
    cmd(3'd4, 2'd0);
    chk("R9 pop-free head", rx_head, 1);
    chk("R9 pop-free frees", pages_used, 3);
    rxreq(g, pg);
    chk("R8 regrant page", pg, 0);
    cmd(3'd5, 2'd2);
    chk("R10 free page", pages_used, 3);
    rxreq(g, pg);
    chk("R8 refuse queue full", g, 0);
    cmd(3'd3, 2'd0);
    chk("R9 pop order", rx_head, 2);
    cmd(3'd3, 2'd0); cmd(3'd3, 2'd0); cmd(3'd3, 2'd0);
    chk("R9 drained", rx_head, 8'h80);
    chk("R9 pop keeps pages", pages_used, 3);
    cmd(3'd3, 2'd0);
    cmd(3'd4, 2'd0);
    chk("R9 empty pop head", rx_head, 8'h80);
    chk("R9 empty pop bitmap", pages_used, 3);

    // R12 arbitration
    cmd(3'd2, 2'd0);
    cmd(3'd1, 2'd0);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_code = 8'h00; rel_valid = 1'b1; rel_page = 2'd0; rx_req = 1'b1;
    #1;
    chk("R12 rx loses to command", rx_grant, 0);
    @(negedge clk);
    cmd_valid = 1'b0;
    #1;
    chk("R12 rx loses to release", rx_grant, 0);
    @(negedge clk);
    rel_valid = 1'b0; rx_req = 1'b0;
    chk("R12 release after command", pages_used, 0);
    chk("R12 rx queue untouched", rx_head, 8'h80);

    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule